// File: doc/BRIEF.md
# Dual-Port Memory Collision Monitor

This block is a synthesizable watcher placed next to a two-port block memory whose ports share one clock. Each port has an enable, a write enable and an address. A port has no read enable of its own. An enabled port always reads, and when its write enable is also high it writes in the same cycle. Each port also has a fixed write mode, given as a 2-bit parameter. The mode decides what the memory does when the other port reads the same location in the same cycle.

In every cycle the monitor checks whether both enabled ports present the same address. If they do, it classifies the access under one fixed rule:

- Two reads are always safe.
- A single writer is safe only when that writer is set to read-first, so that the other port sees the old word.
- Everything else is a collision, including two writes.

Illegal collisions produce a one-cycle pulse, a sticky flag, a saturating count and a capture of the first offending address. Legal same-address accesses are counted separately. The block holds no memory data. All pins are plain level signals, sampled or updated at the rising clock edge; no data stream passes through the block, so there is no handshake.

Top module: `dpram_collision_monitor`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero at that edge.
- R2: A same-address access occurs only when both enables are high and the two addresses match on every bit; otherwise neither counter moves and no pulse is raised.
- R3: A same-address access where neither port writes is legal: `ok_count` increments and no error is raised.
- R4: A same-address access where exactly one port writes and that port's mode is read-first (code 2'b00) is legal.
- R5: A same-address access where exactly one port writes and that port's mode is write-first (2'b01), no-change (2'b10) or the unused code 2'b11 is illegal.
- R6: The mode parameter of the port that only reads has no effect on the classification.
- R7: A same-address access where both ports write is illegal, whatever the modes are.
- R8: `err_pulse` is high for exactly the one cycle that follows each rising edge at which an illegal access was sampled.
- R9: `err_sticky` rises together with the first error pulse, stays high, and is cleared only by `rst`.
- R10: `err_count` counts illegal accesses and `ok_count` counts legal ones. Each is 16 bits wide and holds at 65535 instead of wrapping.
- R11: `first_err_addr` takes the address of the first illegal access after reset. It keeps that value through later collisions until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of both memory ports |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Port A enable (gates both read and write) |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A address |
| b_en | input | 1 | Port B enable (gates both read and write) |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W | Port B address |
| err_pulse | output | 1 | One-cycle pulse per illegal collision |
| err_sticky | output | 1 | Set by any illegal collision, cleared by reset |
| err_count | output | CNT_W | Saturating count of illegal collisions |
| ok_count | output | CNT_W | Saturating count of legal same-address accesses |
| first_err_addr | output | ADDR_W | Address of the first illegal collision |

## Verification
All results are due one edge after the stimulus. The port values sampled at a rising edge show up on the pulse, flag, counters and captured address right after that same edge. The bench therefore applies each stimulus at the falling edge, lets one rising edge pass, and compares every output a quarter period later against a model it has already advanced by one step. Two instances with different mode pairs receive identical stimulus, so the writer's mode and the reader's mode can be told apart in the same cycle.

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;

  // Write-mode codes carried by the per-port mode parameters
  localparam logic [1:0] WM_READ_FIRST  = 2'b00;
  localparam logic [1:0] WM_WRITE_FIRST = 2'b01;
  localparam logic [1:0] WM_NO_CHANGE   = 2'b10;

  typedef enum logic [1:0] {
    CL_NONE    = 2'b00,
    CL_LEGAL   = 2'b01,
    CL_ILLEGAL = 2'b10
  } coll_e;

  // A lone writer is harmless only if it hands the old word to the other port
  function automatic logic writer_is_safe(input logic [1:0] mode);
    return mode == WM_READ_FIRST;
  endfunction

endpackage

// File: rtl/dpcm_classify.sv
module dpcm_classify
  import dpcm_pkg::*;
#(
  parameter int         ADDR_W = 10,
  parameter logic [1:0] MODE_A = WM_READ_FIRST,
  parameter logic [1:0] MODE_B = WM_READ_FIRST
) (
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  output coll_e             cls
);

  localparam logic A_SAFE = writer_is_safe(MODE_A);
  localparam logic B_SAFE = writer_is_safe(MODE_B);

  logic same_addr;
  logic both_on;

  assign same_addr = (a_addr == b_addr);
  assign both_on   = a_en & b_en;

  always_comb begin
    cls = CL_NONE;
    if (both_on && same_addr) begin
      unique case ({a_we, b_we})
        2'b00:   cls = CL_LEGAL;
        2'b10:   cls = A_SAFE ? CL_LEGAL : CL_ILLEGAL;
        2'b01:   cls = B_SAFE ? CL_LEGAL : CL_ILLEGAL;
        default: cls = CL_ILLEGAL;
      endcase
    end
  end

endmodule

// File: rtl/dpcm_satcnt.sv
module dpcm_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // R10: a full counter stays full
  p_sat_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R10: below the limit, an increment request advances by exactly one
  p_step_r10: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

  // R10: without a request the count does not move
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));

endmodule

// File: rtl/dpcm_err_track.sv
module dpcm_err_track #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              illegal,
  input  logic [ADDR_W-1:0] addr,
  output logic              err_pulse,
  output logic              err_sticky,
  output logic [ADDR_W-1:0] first_err_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse      <= 1'b0;
      err_sticky     <= 1'b0;
      first_err_addr <= '0;
    end else begin
      err_pulse <= illegal;
      if (illegal) err_sticky <= 1'b1;
      if (illegal && !err_sticky) first_err_addr <= addr;
    end
  end

  // R9: flag never drops without reset
  p_sticky_keep_r9: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);

  // R9: any pulse comes with the flag raised
  p_pulse_flag_r9: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> err_sticky);

  // R11: once captured, the first address is frozen
  p_first_hold_r11: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> $stable(first_err_addr));

endmodule

// File: rtl/dpram_collision_monitor.sv
module dpram_collision_monitor
  import dpcm_pkg::*;
#(
  parameter int         ADDR_W = 10,
  parameter int         CNT_W  = 16,
  parameter logic [1:0] MODE_A = WM_READ_FIRST,
  parameter logic [1:0] MODE_B = WM_WRITE_FIRST
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              err_pulse,
  output logic              err_sticky,
  output logic [CNT_W-1:0]  err_count,
  output logic [CNT_W-1:0]  ok_count,
  output logic [ADDR_W-1:0] first_err_addr
);

  coll_e cls;
  logic  is_illegal;
  logic  is_legal;

  dpcm_classify #(
    .ADDR_W(ADDR_W), .MODE_A(MODE_A), .MODE_B(MODE_B)
  ) u_cls (
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
    .cls(cls)
  );

  assign is_illegal = (cls == CL_ILLEGAL);
  assign is_legal   = (cls == CL_LEGAL);

  dpcm_err_track #(.ADDR_W(ADDR_W)) u_err (
    .clk(clk), .rst(rst), .illegal(is_illegal), .addr(a_addr),
    .err_pulse(err_pulse), .err_sticky(err_sticky),
    .first_err_addr(first_err_addr)
  );

  dpcm_satcnt #(.CNT_W(CNT_W)) u_bad_cnt (
    .clk(clk), .rst(rst), .inc(is_illegal), .cnt(err_count)
  );

  dpcm_satcnt #(.CNT_W(CNT_W)) u_ok_cnt (
    .clk(clk), .rst(rst), .inc(is_legal), .cnt(ok_count)
  );

  // R7: two writers on one address always flag an error next cycle
  p_dual_write_err_r7: assert property (@(posedge clk) disable iff (rst)
    (a_en && b_en && a_we && b_we && a_addr == b_addr) |=> err_pulse);

  // R3: two readers on one address never flag an error
  p_dual_read_ok_r3: assert property (@(posedge clk) disable iff (rst)
    (a_en && b_en && !a_we && !b_we && a_addr == b_addr) |=> !err_pulse);

  // R2: with a port switched off nothing is classified
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!a_en || !b_en) |=> (!err_pulse && $stable(ok_count) && $stable(err_count)));

  // R2: differing addresses never collide
  p_addr_differ_r2: assert property (@(posedge clk) disable iff (rst)
    (a_addr != b_addr) |=> !err_pulse);

endmodule

// File: tb/sim_dpram_collision_monitor.sv
`timescale 1ns/1ps
module sim_dpram_collision_monitor;

  localparam int AW = 10;
  localparam int CW = 16;
  localparam int SAT = 65535;
  localparam logic [1:0] M0A = 2'b00, M0B = 2'b01;
  localparam logic [1:0] M1A = 2'b10, M1B = 2'b00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;

  logic p0, s0, p1, s1;
  logic [CW-1:0] e0, o0, e1, o1;
  logic [AW-1:0] f0, f1;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  int  m_err[2], m_ok[2], m_first[2];
  bit  m_pulse[2], m_sticky[2];

  always #10 clk = ~clk;

  dpram_collision_monitor #(.ADDR_W(AW), .CNT_W(CW), .MODE_A(M0A), .MODE_B(M0B)) u0 (
    .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
    .err_pulse(p0), .err_sticky(s0), .err_count(e0), .ok_count(o0),
    .first_err_addr(f0));

  dpram_collision_monitor #(.ADDR_W(AW), .CNT_W(CW), .MODE_A(M1A), .MODE_B(M1B)) u1 (
    .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
    .err_pulse(p1), .err_sticky(s1), .err_count(e1), .ok_count(o1),
    .first_err_addr(f1));

  // 0 none, 1 legal, 2 illegal -- written from the rules, not from the RTL
  function automatic int expect_cls(input logic [1:0] ma, input logic [1:0] mb,
                                    input bit ae, input bit aw, input int aa,
                                    input bit be, input bit bw, input int ba);
    if (!(ae && be) || aa != ba) return 0;
    if (!aw && !bw) return 1;
    if (aw && bw) return 2;
    if (aw) return (ma == 2'b00) ? 1 : 2;
    return (mb == 2'b00) ? 1 : 2;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "u0 pulse", p0, m_pulse[0]);   cmp(tag, "u1 pulse", p1, m_pulse[1]);
    cmp(tag, "u0 sticky", s0, m_sticky[0]); cmp(tag, "u1 sticky", s1, m_sticky[1]);
    cmp(tag, "u0 errcnt", e0, m_err[0]);    cmp(tag, "u1 errcnt", e1, m_err[1]);
    cmp(tag, "u0 okcnt", o0, m_ok[0]);      cmp(tag, "u1 okcnt", o1, m_ok[1]);
    cmp(tag, "u0 first", f0, m_first[0]);   cmp(tag, "u1 first", f1, m_first[1]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; a_en = 0; b_en = 0; a_we = 0; b_we = 0;
    @(posedge clk); #5;
    for (int i = 0; i < 2; i++) begin
      m_err[i] = 0; m_ok[i] = 0; m_first[i] = 0; m_pulse[i] = 0; m_sticky[i] = 0;
    end
    check_all("R1");
    @(negedge clk); rst = 0;
  endtask

  task automatic drive(input bit ae, input bit aw, input int aa,
                       input bit be, input bit bw, input int ba,
                       input string tag, input bit chk);
    int c;
    @(negedge clk);
    a_en = ae; a_we = aw; a_addr = AW'(aa);
    b_en = be; b_we = bw; b_addr = AW'(ba);
    for (int i = 0; i < 2; i++) begin
      c = (i == 0) ? expect_cls(M0A, M0B, ae, aw, aa, be, bw, ba)
                   : expect_cls(M1A, M1B, ae, aw, aa, be, bw, ba);
      m_pulse[i] = (c == 2);
      if (c == 2) begin
        if (!m_sticky[i]) m_first[i] = aa;
        m_sticky[i] = 1;
        if (m_err[i] != SAT) m_err[i]++;
      end
      if (c == 1 && m_ok[i] != SAT) m_ok[i]++;
    end
    @(posedge clk); #5;
    if (chk) check_all(tag);
  endtask

  initial begin
    #(20 * 195000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!finished) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c011));
    do_reset();
    drive(1, 1, 5, 1, 1, 6, "R2", 1);          // different addresses
    drive(0, 1, 7, 1, 1, 7, "R2", 1);          // A disabled
    drive(1, 0, 9, 0, 0, 9, "R2", 1);          // B disabled
    drive(1, 1, 12, 1, 1, 12 + 512, "R2", 1);  // differ only in top bit
    drive(1, 0, 3, 1, 0, 3, "R3", 1);          // two reads
    drive(1, 0, 3, 1, 0, 3, "R3", 1);
    drive(1, 1, 20, 1, 0, 20, "R4", 1);        // A writes: u0 read-first ok, u1 no-change bad
    drive(0, 0, 0, 0, 0, 0, "R8", 1);          // pulse lasts one cycle
    drive(1, 0, 21, 1, 1, 21, "R6", 1);        // B writes: u0 write-first bad, u1 ok
    drive(1, 1, 33, 1, 1, 33, "R7", 1);        // both write
    drive(1, 1, 33, 1, 1, 33, "R8", 1);        // back-to-back pulse
    drive(0, 0, 0, 0, 0, 0, "R9", 1);          // sticky stays
    drive(1, 1, 44, 1, 1, 44, "R11", 1);       // first address unchanged
    drive(1, 1, 40, 1, 0, 40, "R5", 1);
    do_reset();                                 // R9 cleared by reset
    drive(1, 1, 99, 1, 0, 99, "R11", 1);
    for (int k = 0; k < 3000; k++) begin
      int aa = int'($urandom_range(0, 3)) + ($urandom_range(0, 7) == 0 ? 512 : 0);
      int ba = int'($urandom_range(0, 3));
      drive($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, aa,
            $urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, ba, "R2", 1);
    end
    do_reset();
    for (int k = 0; k < SAT + 3; k++) drive(1, 1, 8, 1, 1, 8, "R10", (k % 4096 == 0) || k > SAT - 3);
    check_all("R10");
    for (int k = 0; k < SAT + 3; k++) drive(1, 0, 2, 1, 0, 2, "R10", (k % 4096 == 0) || k > SAT - 3);
    check_all("R10");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule